// File: doc/BRIEF.md
# Card Host Write-Start and Flow-Error Controller

This block sits between the transmit FIFO of a memory-card host and the engine that drives the data lines. It decides in which cycle a write data block may begin. The decision depends on the FIFO fill level, the programmed block length and an eager-start mode bit. A short block is held back until all of its words are in the FIFO. A long block starts at a quarter or a half of the FIFO depth, so that the FIFO can keep the line busy without starving.

The block also watches for FIFO overflow (a push while the FIFO is full) and underflow (a pop from an empty FIFO during an active write). It holds these as sticky flags. A mode bit selects how the flags clear: either by a status read, or by the next read or write command.

A third part counts the blocks of a write transfer. It places a pending command either at the end of each block or at the end of the final block. The final-block option is latched when the write command is issued.

Top module: `card_wr_ctrl`

## Requirements
- R1: When eager mode is set (`cfg_eager_start_i`=1), `wr_start_o` pulses in the cycle after an edge at which the transfer is active, the unit is armed and `fifo_lvl_i` is at least 1.
- R2: When eager mode is clear and the block length is at least 3/4 of DEPTH, the start threshold is DEPTH/2 words (8 for DEPTH=16).
- R3: When eager mode is clear and the block length is at least DEPTH/2 but below 3/4 of DEPTH, the start threshold is DEPTH/4 words.
- R4: When eager mode is clear and the block length is below DEPTH/2, the start threshold is the whole block length. A length of 0 is treated as 1.
- R5: `wr_start_o` is a one-cycle pulse, given at most once per block. It re-arms only after the block's last word has been popped, that is, after `blk_len_i` pops counted from the start pulse.
- R6: `ovf_o` sets on a push while `fifo_lvl_i`==DEPTH. `udf_o` sets on a pop while `fifo_lvl_i`==0 and a block is in progress. A set event in the same cycle as a clear event leaves the flag set.
- R7: With `cfg_rd_clear_i`=1, a `stat_rd_i` strobe clears both flags. Command strobes then have no effect on them.
- R8: With `cfg_rd_clear_i`=0, a `wr_cmd_i` or `rd_cmd_i` strobe clears both flags. `stat_rd_i` then has no effect on them.
- R9: When the last-block option was sampled as 1 and the block count is nonzero, a pending command produces `pend_cmd_o` only at the end of the final block.
- R10: When the last-block option was sampled as 0, or the block count is 0, a pending command produces `pend_cmd_o` one cycle after the end of the current block.
- R11: `wr_cmd_i` samples `cfg_last_sync_i` and `blk_cnt_i`, and later changes to `cfg_last_sync_i` are ignored. A nonzero count ends the transfer after that many blocks, so no further start pulse occurs. A count of 0 gives an unbounded transfer.
- R12: After reset, all outputs are 0, the unit is armed and no transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_eager_start_i | input | 1 | 1: start a block on the first word |
| cfg_rd_clear_i | input | 1 | 1: a status read clears the flow flags; 0: a command clears them |
| cfg_last_sync_i | input | 1 | 1: issue the pending command after the final block |
| blk_len_i | input | BLEN_W | Block length in FIFO words |
| blk_cnt_i | input | BCNT_W | Blocks per transfer, 0 = unbounded |
| fifo_lvl_i | input | LVL_W | Current FIFO fill level |
| push_i | input | 1 | FIFO write strobe |
| pop_i | input | 1 | Data engine read strobe |
| stat_rd_i | input | 1 | Status read strobe |
| wr_cmd_i | input | 1 | Write data command issued |
| rd_cmd_i | input | 1 | Read data command issued |
| pend_req_i | input | 1 | A command is waiting to be sent |
| wr_start_o | output | 1 | Block start pulse |
| pend_cmd_o | output | 1 | Send the pending command now |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
The embedded properties check on every cycle that start pulses last one cycle and occur only in an active transfer. They also check that an eager start or a half-depth start saw enough data. For the flags, they check that each one rises only on its set event and falls only under the clear event of the selected policy. For the pending command, they check that it follows a block end, and that a final-block command closes the transfer.

The exact threshold boundaries, the block counting across a multi-block transfer and the sampling of the final-block option at command time need the bench. Its reference model and directed scenarios cover these, together with set-over-clear collisions.

// File: rtl/card_wr_pkg.sv
package card_wr_pkg;
  typedef enum logic [1:0] {
    THR_ONE,
    THR_HALF,
    THR_QUARTER,
    THR_BLOCK
  } thr_sel_e;
endpackage

// File: rtl/cwc_start_gate.sv
module cwc_start_gate
  import card_wr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int BLEN_W = 12,
  parameter int LVL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eager_i,
  input  logic [BLEN_W-1:0] blk_len_i,
  input  logic [LVL_W-1:0]  fifo_lvl_i,
  input  logic              pop_i,
  input  logic              wr_cmd_i,
  input  logic              xfer_act_i,
  output logic              wr_start_o,
  output logic              busy_o,
  output logic              blk_end_o
);
  localparam logic [BLEN_W-1:0] QTR  = BLEN_W'(DEPTH >> 2);
  localparam logic [BLEN_W-1:0] HALF = BLEN_W'(DEPTH >> 1);
  localparam logic [BLEN_W-1:0] TQ   = HALF + QTR;

  thr_sel_e          sel;
  logic [BLEN_W-1:0] thr, len_eff, lvl_ext, pop_cnt_q;
  logic              armed_q, busy_q, start_q, go;

  always_comb begin
    len_eff = (blk_len_i == '0) ? BLEN_W'(1) : blk_len_i;
    lvl_ext = BLEN_W'(fifo_lvl_i);
    if (eager_i)             sel = THR_ONE;
    else if (len_eff >= TQ)   sel = THR_HALF;
    else if (len_eff >= HALF) sel = THR_QUARTER;
    else                      sel = THR_BLOCK;
    case (sel)
      THR_ONE:     thr = BLEN_W'(1);
      THR_HALF:    thr = HALF;
      THR_QUARTER: thr = QTR;
      default:     thr = len_eff;
    endcase
  end

  assign go        = armed_q && xfer_act_i && (lvl_ext >= thr) && !wr_cmd_i;
  assign blk_end_o = busy_q && pop_i && (pop_cnt_q == len_eff - BLEN_W'(1)) && !wr_cmd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b1;
      busy_q    <= 1'b0;
      start_q   <= 1'b0;
      pop_cnt_q <= '0;
    end else if (wr_cmd_i) begin
      armed_q   <= 1'b1;
      busy_q    <= 1'b0;
      start_q   <= 1'b0;
      pop_cnt_q <= '0;
    end else begin
      start_q <= go;
      if (go) begin
        armed_q   <= 1'b0;
        busy_q    <= 1'b1;
        pop_cnt_q <= '0;
      end else if (blk_end_o) begin
        armed_q <= 1'b1;
        busy_q  <= 1'b0;
      end else if (busy_q && pop_i) begin
        pop_cnt_q <= pop_cnt_q + BLEN_W'(1);
      end
    end
  end

  assign wr_start_o = start_q;
  assign busy_o     = busy_q;

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |=> !wr_start_o);
  a_r5_only_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |-> $past(xfer_act_i));
  a_r1_eager_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_start_o && $past(eager_i)) |-> ($past(fifo_lvl_i) != '0));
  a_r2_half_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_start_o && !$past(eager_i) && ($past(blk_len_i) >= TQ)) |-> ($past(lvl_ext) >= HALF));
endmodule

// File: rtl/cwc_blk_sched.sv
module cwc_blk_sched #(
  parameter int BCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_sync_i,
  input  logic [BCNT_W-1:0] blk_cnt_i,
  input  logic              wr_cmd_i,
  input  logic              pend_req_i,
  input  logic              blk_end_i,
  output logic              xfer_act_o,
  output logic              pend_cmd_o
);
  logic [BCNT_W-1:0] cnt_q;
  logic              lsync_q, act_q, pend_q, fire_q, fire;

  assign fire = blk_end_i && pend_q && (!lsync_q || cnt_q == BCNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      lsync_q <= 1'b0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= fire;
      pend_q <= pend_req_i | (pend_q & ~fire);
      if (wr_cmd_i) begin
        cnt_q   <= blk_cnt_i;
        lsync_q <= last_sync_i && (blk_cnt_i != '0);
        act_q   <= 1'b1;
      end else if (blk_end_i && cnt_q != '0) begin
        cnt_q <= cnt_q - BCNT_W'(1);
        if (cnt_q == BCNT_W'(1)) act_q <= 1'b0;
      end
    end
  end

  assign xfer_act_o = act_q;
  assign pend_cmd_o = fire_q;

  a_r10_after_blk_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_cmd_o |-> $past(blk_end_i));
  a_r11_end_on_blk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xfer_act_o) |-> $past(blk_end_i));
  a_r9_final_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_cmd_o && $past(lsync_q)) |-> !xfer_act_o);
endmodule

// File: rtl/cwc_flow_err.sv
module cwc_flow_err #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] fifo_lvl_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             busy_i,
  input  logic             rd_clr_mode_i,
  input  logic             stat_rd_i,
  input  logic             wr_cmd_i,
  input  logic             rd_cmd_i,
  output logic             ovf_o,
  output logic             udf_o
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic ovf_q, udf_q, ovf_set, udf_set, clr;

  assign ovf_set = push_i && (fifo_lvl_i == FULL);
  assign udf_set = pop_i && (fifo_lvl_i == '0) && busy_i;
  assign clr     = rd_clr_mode_i ? stat_rd_i : (wr_cmd_i || rd_cmd_i);

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_set | (ovf_q & ~clr);
      udf_q <= udf_set | (udf_q & ~clr);
    end
  end

  assign ovf_o = ovf_q;
  assign udf_o = udf_q;

  a_r6_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> ($past(push_i) && $past(fifo_lvl_i) == FULL));
  a_r6_udf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(udf_o) |-> ($past(pop_i) && $past(busy_i)));
  a_r7_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ovf_o) && $past(rd_clr_mode_i)) |-> $past(stat_rd_i));
  a_r8_cmd_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(udf_o) && !$past(rd_clr_mode_i)) |-> $past(wr_cmd_i || rd_cmd_i));
endmodule

// File: rtl/card_wr_ctrl.sv
module card_wr_ctrl #(
  parameter int DEPTH  = 16,
  parameter int BLEN_W = 12,
  parameter int BCNT_W = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_eager_start_i,
  input  logic              cfg_rd_clear_i,
  input  logic              cfg_last_sync_i,
  input  logic [BLEN_W-1:0] blk_len_i,
  input  logic [BCNT_W-1:0] blk_cnt_i,
  input  logic [LVL_W-1:0]  fifo_lvl_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              stat_rd_i,
  input  logic              wr_cmd_i,
  input  logic              rd_cmd_i,
  input  logic              pend_req_i,
  output logic              wr_start_o,
  output logic              pend_cmd_o,
  output logic              ovf_o,
  output logic              udf_o
);
  logic xfer_act, busy, blk_end;

  cwc_start_gate #(.DEPTH(DEPTH), .BLEN_W(BLEN_W), .LVL_W(LVL_W)) u_start (
    .clk_i, .rst_ni,
    .eager_i    (cfg_eager_start_i),
    .blk_len_i,
    .fifo_lvl_i,
    .pop_i,
    .wr_cmd_i,
    .xfer_act_i (xfer_act),
    .wr_start_o,
    .busy_o     (busy),
    .blk_end_o  (blk_end)
  );

  cwc_blk_sched #(.BCNT_W(BCNT_W)) u_sched (
    .clk_i, .rst_ni,
    .last_sync_i (cfg_last_sync_i),
    .blk_cnt_i,
    .wr_cmd_i,
    .pend_req_i,
    .blk_end_i   (blk_end),
    .xfer_act_o  (xfer_act),
    .pend_cmd_o
  );

  cwc_flow_err #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_flow (
    .clk_i, .rst_ni,
    .fifo_lvl_i,
    .push_i,
    .pop_i,
    .busy_i        (busy),
    .rd_clr_mode_i (cfg_rd_clear_i),
    .stat_rd_i,
    .wr_cmd_i,
    .rd_cmd_i,
    .ovf_o,
    .udf_o
  );
endmodule

// File: tb/card_wr_ctrl_bench.sv
module card_wr_ctrl_bench;
  localparam int D = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic eager = 0, rdclr = 0, lsync = 0;
  logic [11:0] bl = '0;
  logic [7:0]  bc = '0;
  logic [4:0]  lvl = '0;
  logic push = 0, pop = 0, stat_rd = 0, wr_cmd = 0, rd_cmd = 0, preq = 0;
  logic ws, pc, ovf, udf;

  int n_tests = 0, n_fail = 0, ws_cnt = 0, pc_cnt = 0;

  always #4 clk = ~clk;

  card_wr_ctrl u_card_wr_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_eager_start_i(eager), .cfg_rd_clear_i(rdclr), .cfg_last_sync_i(lsync),
    .blk_len_i(bl), .blk_cnt_i(bc), .fifo_lvl_i(lvl),
    .push_i(push), .pop_i(pop), .stat_rd_i(stat_rd),
    .wr_cmd_i(wr_cmd), .rd_cmd_i(rd_cmd), .pend_req_i(preq),
    .wr_start_o(ws), .pend_cmd_o(pc), .ovf_o(ovf), .udf_o(udf)
  );

  // behavioural reference model
  bit m_armed, m_busy, m_ws, m_act, m_ls, m_pend, m_pc, m_ovf, m_udf;
  int m_pcnt, m_cnt, t_len, t_thr;
  bit t_go, t_be, t_fire, t_clr, t_os, t_us;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 1; m_busy = 0; m_ws = 0; m_act = 0; m_ls = 0;
      m_pend = 0; m_pc = 0; m_ovf = 0; m_udf = 0; m_pcnt = 0; m_cnt = 0;
    end else begin
      t_len = (bl == 0) ? 1 : int'(bl);
      if (eager)              t_thr = 1;
      else if (t_len >= 3*D/4) t_thr = D/2;
      else if (t_len >= D/2)   t_thr = D/4;
      else                     t_thr = t_len;
      t_go   = m_armed && m_act && (int'(lvl) >= t_thr) && !wr_cmd;
      t_be   = m_busy && pop && (m_pcnt == t_len - 1) && !wr_cmd;
      t_fire = t_be && m_pend && (!m_ls || m_cnt == 1);
      t_os   = push && (int'(lvl) == D);
      t_us   = pop && (lvl == 0) && m_busy;
      t_clr  = rdclr ? stat_rd : (wr_cmd || rd_cmd);
      m_ovf  = t_os || (m_ovf && !t_clr);
      m_udf  = t_us || (m_udf && !t_clr);
      m_pc   = t_fire;
      m_pend = preq || (m_pend && !t_fire);
      if (wr_cmd) begin
        m_cnt = int'(bc); m_ls = lsync && (bc != 0); m_act = 1;
      end else if (t_be && m_cnt != 0) begin
        if (m_cnt == 1) m_act = 0;
        m_cnt = m_cnt - 1;
      end
      if (wr_cmd) begin
        m_armed = 1; m_busy = 0; m_ws = 0; m_pcnt = 0;
      end else begin
        m_ws = t_go;
        if (t_go) begin m_armed = 0; m_busy = 1; m_pcnt = 0; end
        else if (t_be) begin m_armed = 1; m_busy = 0; end
        else if (m_busy && pop) m_pcnt = m_pcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string ws_tag();
    int len = (bl == 0) ? 1 : int'(bl);
    if (eager) return "R1";
    if (len >= 3*D/4) return "R2";
    if (len >= D/2) return "R3";
    return "R4";
  endfunction

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      ws_cnt += int'(ws);
      pc_cnt += int'(pc);
      chk(ws == m_ws, {ws_tag(), " start pulse"}, int'(ws), int'(m_ws));
      chk(pc == m_pc, m_ls ? "R9 pending cmd" : "R10 pending cmd", int'(pc), int'(m_pc));
      chk(ovf == m_ovf, (m_ovf || t_os) ? "R6 ovf" : (rdclr ? "R7 ovf" : "R8 ovf"), int'(ovf), int'(m_ovf));
      chk(udf == m_udf, (m_udf || t_us) ? "R6 udf" : (rdclr ? "R7 udf" : "R8 udf"), int'(udf), int'(m_udf));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic start_xfer(input int len, input int cnt, input bit ls, input bit eg);
    bl = 12'(len); bc = 8'(cnt); lsync = ls; eager = eg;
    wr_cmd = 1; step(1); wr_cmd = 0;
    ws_cnt = 0; pc_cnt = 0;
  endtask

  task automatic run_block(input int fill, input int len);
    lvl = 5'(fill); step(2);
    pop = 1; step(len); pop = 0;
    lvl = '0; step(1);
  endtask

  task automatic pulse_preq();
    preq = 1; step(1); preq = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    step(3);
    chk(!ws && !pc && !ovf && !udf, "R12 reset outputs", {ws, pc, ovf, udf}, 0);
    rst_n = 1; step(2);
    lvl = 5'd8; step(3);
    chk(ws_cnt == 0, "R12 no start before a command", ws_cnt, 0);
    lvl = '0;

    // R4: short block waits for the whole block
    start_xfer(5, 1, 0, 0);
    for (int k = 1; k <= 4; k++) begin lvl = 5'(k); step(1); end
    step(1);
    chk(ws_cnt == 0, "R4 no start below block length", ws_cnt, 0);
    lvl = 5'd5; step(2);
    chk(ws_cnt == 1, "R4 start at block length", ws_cnt, 1);
    pop = 1; step(5); pop = 0; step(4);
    chk(ws_cnt == 1, "R11 transfer over after count", ws_cnt, 1);
    lvl = '0;

    // R4 boundary: length 7 just below D/2
    start_xfer(7, 1, 0, 0);
    lvl = 5'd6; step(3);
    chk(ws_cnt == 0, "R4 len7 at level6", ws_cnt, 0);
    lvl = 5'd7; step(2);
    chk(ws_cnt == 1, "R4 len7 at level7", ws_cnt, 1);
    pop = 1; step(7); pop = 0; lvl = '0; step(1);

    // R2: length 12 -> half full
    start_xfer(12, 1, 0, 0);
    lvl = 5'd7; step(3);
    chk(ws_cnt == 0, "R2 below half", ws_cnt, 0);
    lvl = 5'd8; step(2);
    chk(ws_cnt == 1, "R2 at half", ws_cnt, 1);
    pop = 1; step(12); pop = 0; lvl = '0; step(1);

    // R3: length 11 -> quarter full
    start_xfer(11, 1, 0, 0);
    lvl = 5'd3; step(3);
    chk(ws_cnt == 0, "R3 below quarter", ws_cnt, 0);
    lvl = 5'd4; step(2);
    chk(ws_cnt == 1, "R3 at quarter", ws_cnt, 1);
    pop = 1; step(11); pop = 0; lvl = '0; step(1);

    // R1 eager start and R5 re-arm across blocks
    start_xfer(12, 2, 0, 1);
    lvl = 5'd1; step(2);
    chk(ws_cnt == 1, "R1 eager start on one word", ws_cnt, 1);
    lvl = 5'd16; step(4);
    chk(ws_cnt == 1, "R5 no second pulse within block", ws_cnt, 1);
    pop = 1; step(12); pop = 0; lvl = '0; step(1);
    run_block(3, 12);
    chk(ws_cnt == 2, "R5 re-armed for second block", ws_cnt, 2);

    // R9 + R11: final-block sync, cfg bit dropped after command
    start_xfer(2, 3, 1, 0);
    lsync = 0;
    pulse_preq();
    run_block(2, 2);
    run_block(2, 2);
    chk(pc_cnt == 0, "R9 held until final block", pc_cnt, 0);
    run_block(2, 2);
    chk(pc_cnt == 1, "R9 sent after final block", pc_cnt, 1);

    // R10: per-block issue
    start_xfer(2, 3, 0, 0);
    pulse_preq();
    run_block(2, 2);
    chk(pc_cnt == 1, "R10 sent after current block", pc_cnt, 1);
    run_block(2, 2);
    chk(pc_cnt == 1, "R10 no repeat without request", pc_cnt, 1);
    pulse_preq();
    run_block(2, 2);
    chk(pc_cnt == 2, "R10 second request", pc_cnt, 2);

    // R10/R11: count zero -> per block, unbounded
    start_xfer(2, 0, 1, 0);
    pulse_preq();
    run_block(2, 2);
    chk(pc_cnt == 1, "R10 zero count per block", pc_cnt, 1);
    run_block(2, 2);
    chk(ws_cnt == 2, "R11 unbounded transfer continues", ws_cnt, 2);

    // R6/R8: command-clear policy
    rdclr = 0;
    lvl = 5'd16; push = 1; step(1); push = 0; step(1);
    chk(ovf == 1, "R6 overflow set", int'(ovf), 1);
    stat_rd = 1; step(1); stat_rd = 0; step(1);
    chk(ovf == 1, "R8 status read ignored", int'(ovf), 1);
    rd_cmd = 1; step(1); rd_cmd = 0; step(1);
    chk(ovf == 0, "R8 command clears", int'(ovf), 0);

    // underflow during a block (unbounded transfer still active)
    eager = 1; lvl = 5'd1; step(2);
    lvl = '0; pop = 1; step(1); pop = 0; step(1);
    chk(udf == 1, "R6 underflow set", int'(udf), 1);

    // R7: read-clear policy
    rdclr = 1;
    rd_cmd = 1; step(1); rd_cmd = 0; step(1);
    chk(udf == 1, "R7 command ignored", int'(udf), 1);
    stat_rd = 1; step(1); stat_rd = 0; step(1);
    chk(udf == 0, "R7 status read clears", int'(udf), 0);
    lvl = 5'd16; push = 1; stat_rd = 1; step(1); push = 0; stat_rd = 0; step(1);
    chk(ovf == 1, "R6 set wins over clear", int'(ovf), 1);
    stat_rd = 1; step(1); stat_rd = 0; step(1);
    chk(ovf == 0, "R7 later read clears", int'(ovf), 0);

    step(3);
    summary();
    $finish;
  end
endmodule